// File: doc/BRIEF.md
# Dual-Accumulator Multiply-Accumulate Engine

This block is the arithmetic datapath of a signal-processing unit. Each cycle it takes two 16-bit operands and an opcode. It then updates one of two 40-bit accumulators. The operation can be a multiply-accumulate, a multiply-subtract, an add of the other accumulator, a barrel shift, a load or a clear. The multiplier is 17 by 17 bits, so one mode bit selects between signed and unsigned operands through sign or zero extension. A fractional mode doubles the product before it is accumulated.

Arithmetic results pass through a shared saturation stage. It can clamp to the full 40-bit range, clamp to a 32-bit range, or be bypassed so that results wrap. Each accumulator has an overflow flag that shows whether its value still fits in 32 signed bits. A sticky flag records every clamp until a clear. Operand fetch, address generation and decode belong to the surrounding core. This engine only sees the already decoded controls, and it writes its result registers once per clock edge.

Top module: `dsp_mac_engine`

## Requirements
- R1: After a synchronous reset both accumulators read zero, both overflow flags are 0 and the sticky flag is 0.
- R2: Opcode 1 (clear) writes zero to the accumulator chosen by `acc_sel` (0 = acc0, 1 = acc1) and clears the sticky flag. The other accumulator keeps its value.
- R3: Opcode 2 (load) writes the sign extension of the 32-bit value {opb, opa} to the selected accumulator.
- R4: Opcode 3 (multiply-accumulate) adds opa*opb to the selected accumulator. Both operands are treated as two's complement when `is_signed`=1 and as unsigned when it is 0. One operation completes per cycle, back to back.
- R5: Opcode 4 (multiply-subtract) subtracts opa*opb from the selected accumulator.
- R6: When `frac_mode`=1 the product is multiplied by two before it is added or subtracted.
- R7: Opcode 5 writes the sum of the selected accumulator and the other accumulator to the selected accumulator.
- R8: Opcode 6 shifts the selected accumulator by the signed 6-bit `shift_amt`. A positive amount shifts arithmetically right and a negative amount shifts left. Magnitudes above 16 act as 16.
- R9: With `sat_en`=1 and `sat_narrow`=0, results of opcodes 3 to 6 outside the 40-bit signed range become 0x7FFFFFFFFF or 0x8000000000.
- R10: With `sat_en`=1 and `sat_narrow`=1, results of opcodes 3 to 6 outside the 32-bit signed range become 0x007FFFFFFF or 0xFF80000000.
- R11: With `sat_en`=0, results wrap modulo 2^40 and the sticky flag is not set.
- R12: On every write to an accumulator, its overflow flag becomes 1 exactly when bits 39 to 31 of the new value are not all equal.
- R13: The sticky flag goes to 1 in the cycle after any clamp. It stays set through all other opcodes and is cleared only by opcode 1.
- R14: Opcodes 0 and 7 change no accumulator and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 3 | Operation code (0 none, 1 clear, 2 load, 3 MAC, 4 MSC, 5 add other, 6 shift, 7 none) |
| acc_sel | input | 1 | Destination accumulator |
| opa | input | 16 | First operand, low half of load value |
| opb | input | 16 | Second operand, high half of load value |
| is_signed | input | 1 | Operands signed when 1 |
| frac_mode | input | 1 | Double the product when 1 |
| sat_en | input | 1 | Enable saturation |
| sat_narrow | input | 1 | Clamp to 32-bit range instead of 40-bit |
| shift_amt | input | 6 | Signed shift count, positive right |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| ovf0 | output | 1 | Accumulator 0 exceeds 32 signed bits |
| ovf1 | output | 1 | Accumulator 1 exceeds 32 signed bits |
| sat_sticky | output | 1 | A clamp has occurred since the last clear |

## Verification
Clamping and the overflow flag update can land on the same edge. In that case the sticky flag rises, and the overflow flag must describe the clamped value rather than the raw sum. In 40-bit mode that clamped value still reads as overflowed, while in 32-bit mode it does not. The bench provokes this by loading a value near the limit and then shifting it left or running a MAC past the limit in each saturation mode. It compares the accumulator, both overflow flags and the sticky flag against a model computed from the requirements in 64-bit integers.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int ACC_W  = 40;
  localparam int OP_W   = 16;
  localparam int NARR_W = 32;
  localparam int SH_W   = 6;
  localparam int MAX_SH = 16;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_CLR   = 3'd1,
    OP_LOAD  = 3'd2,
    OP_MAC   = 3'd3,
    OP_MSC   = 3'd4,
    OP_ADD   = 3'd5,
    OP_SHIFT = 3'd6,
    OP_NOP2  = 3'd7
  } mac_op_e;
endpackage

// File: rtl/mac_multiplier.sv
module mac_multiplier #(
  parameter int OPW = 16,
  localparam int EW = OPW + 1,
  localparam int PW = 2 * EW,
  localparam int OUTW = PW + 1
) (
  input  logic [OPW-1:0]         a,
  input  logic [OPW-1:0]         b,
  input  logic                   is_signed,
  input  logic                   frac,
  output logic signed [OUTW-1:0] prod
);
  logic signed [EW-1:0] ext_a, ext_b;
  logic signed [PW-1:0] raw;

  // one extra bit covers both signed and unsigned operands
  assign ext_a = {is_signed & a[OPW-1], a};
  assign ext_b = {is_signed & b[OPW-1], b};
  assign raw   = ext_a * ext_b;
  assign prod  = frac ? {raw, 1'b0} : {raw[PW-1], raw};
endmodule

// File: rtl/mac_shifter.sv
module mac_shifter #(
  parameter int ACCW = 40,
  parameter int SHW = 6,
  parameter int MAXSH = 16,
  localparam int OUTW = ACCW + MAXSH + 1
) (
  input  logic [ACCW-1:0]        acc,
  input  logic [SHW-1:0]         amt,
  output logic signed [OUTW-1:0] res
);
  logic [SHW-1:0] neg_amt, mag;
  logic signed [OUTW-1:0] ext;

  assign neg_amt = -amt;
  assign ext = {{(OUTW-ACCW){acc[ACCW-1]}}, acc};

  always_comb begin
    if (amt[SHW-1]) mag = (neg_amt > SHW'(MAXSH)) ? SHW'(MAXSH) : neg_amt;
    else            mag = (amt > SHW'(MAXSH))     ? SHW'(MAXSH) : amt;
  end

  assign res = amt[SHW-1] ? (ext <<< mag) : (ext >>> mag);
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate #(
  parameter int INW = 57,
  parameter int ACCW = 40,
  parameter int NARW = 32
) (
  input  logic [INW-1:0]  val,
  input  logic            sat_en,
  input  logic            narrow,
  output logic [ACCW-1:0] out,
  output logic            clamped
);
  localparam logic [ACCW-1:0] WIDE_MAX = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic [ACCW-1:0] WIDE_MIN = {1'b1, {(ACCW-1){1'b0}}};
  localparam logic [ACCW-1:0] NARR_MAX = {{(ACCW-NARW+1){1'b0}}, {(NARW-1){1'b1}}};
  localparam logic [ACCW-1:0] NARR_MIN = {{(ACCW-NARW+1){1'b1}}, {(NARW-1){1'b0}}};

  logic wide_fits, narr_fits, fits;

  assign wide_fits = (&val[INW-1:ACCW-1]) | ~(|val[INW-1:ACCW-1]);
  assign narr_fits = (&val[INW-1:NARW-1]) | ~(|val[INW-1:NARW-1]);
  assign fits      = narrow ? narr_fits : wide_fits;

  always_comb begin
    clamped = 1'b0;
    out     = val[ACCW-1:0];
    if (sat_en && !fits) begin
      clamped = 1'b1;
      if (narrow) out = val[INW-1] ? NARR_MIN : NARR_MAX;
      else        out = val[INW-1] ? WIDE_MIN : WIDE_MAX;
    end
  end
endmodule

// File: rtl/dsp_mac_engine.sv
module dsp_mac_engine
  import mac_pkg::*;
#(
  parameter int ACCW = ACC_W,
  parameter int OPW = OP_W,
  parameter int NARW = NARR_W,
  parameter int SHW = SH_W,
  parameter int MAXSH = MAX_SH,
  localparam int WIDEW = ACCW + MAXSH + 1,
  localparam int PRODW = 2 * (OPW + 1) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      opcode,
  input  logic            acc_sel,
  input  logic [OPW-1:0]  opa,
  input  logic [OPW-1:0]  opb,
  input  logic            is_signed,
  input  logic            frac_mode,
  input  logic            sat_en,
  input  logic            sat_narrow,
  input  logic [SHW-1:0]  shift_amt,
  output logic [ACCW-1:0] acc0,
  output logic [ACCW-1:0] acc1,
  output logic            ovf0,
  output logic            ovf1,
  output logic            sat_sticky
);
  logic [ACCW-1:0] acc_q [2];
  logic [1:0]      ovf_q;
  logic            sticky_q;

  logic [ACCW-1:0]         sel_acc, oth_acc, sat_val, wr_val;
  logic signed [PRODW-1:0] prod;
  logic signed [WIDEW-1:0] shifted, wide_sel, wide_oth, wide_prod, arith;
  logic                    is_arith, do_write, clamped;

  assign sel_acc = acc_q[acc_sel];
  assign oth_acc = acc_q[~acc_sel];

  mac_multiplier #(.OPW(OPW)) u_mul (
    .a(opa), .b(opb), .is_signed(is_signed), .frac(frac_mode), .prod(prod)
  );

  mac_shifter #(.ACCW(ACCW), .SHW(SHW), .MAXSH(MAXSH)) u_shift (
    .acc(sel_acc), .amt(shift_amt), .res(shifted)
  );

  assign wide_sel  = {{(WIDEW-ACCW){sel_acc[ACCW-1]}}, sel_acc};
  assign wide_oth  = {{(WIDEW-ACCW){oth_acc[ACCW-1]}}, oth_acc};
  assign wide_prod = {{(WIDEW-PRODW){prod[PRODW-1]}}, prod};

  always_comb begin
    is_arith = 1'b1;
    arith    = '0;
    unique case (opcode)
      OP_MAC:   arith = wide_sel + wide_prod;
      OP_MSC:   arith = wide_sel - wide_prod;
      OP_ADD:   arith = wide_sel + wide_oth;
      OP_SHIFT: arith = shifted;
      default:  is_arith = 1'b0;
    endcase
  end

  mac_saturate #(.INW(WIDEW), .ACCW(ACCW), .NARW(NARW)) u_sat (
    .val(arith), .sat_en(sat_en & is_arith), .narrow(sat_narrow),
    .out(sat_val), .clamped(clamped)
  );

  always_comb begin
    do_write = 1'b1;
    wr_val   = sat_val;
    case (opcode)
      OP_CLR:  wr_val = '0;
      OP_LOAD: wr_val = {{(ACCW-2*OPW){opb[OPW-1]}}, opb, opa};
      OP_NOP, OP_NOP2: do_write = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q[0] <= '0;
      acc_q[1] <= '0;
      ovf_q    <= '0;
      sticky_q <= 1'b0;
    end else begin
      if (do_write) begin
        acc_q[acc_sel] <= wr_val;
        ovf_q[acc_sel] <= ~((&wr_val[ACCW-1:NARW-1]) | ~(|wr_val[ACCW-1:NARW-1]));
      end
      if (opcode == OP_CLR)  sticky_q <= 1'b0;
      else if (clamped)      sticky_q <= 1'b1;
    end
  end

  assign acc0       = acc_q[0];
  assign acc1       = acc_q[1];
  assign ovf0       = ovf_q[0];
  assign ovf1       = ovf_q[1];
  assign sat_sticky = sticky_q;

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (opcode == OP_CLR && !acc_sel) |=> (acc0 == '0 && !sat_sticky)); // R2
  AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!acc_sel) |=> $stable(acc1)); // R14
  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    (sat_en && sat_narrow && !acc_sel && opcode inside {OP_MAC, OP_MSC, OP_ADD, OP_SHIFT})
    |=> ((&acc0[ACCW-1:NARW-1]) || !(|acc0[ACCW-1:NARW-1]))); // R10
  AST_OVF_TRACK: assert property (@(posedge clk) disable iff (rst)
    ovf0 == !((&acc0[ACCW-1:NARW-1]) || !(|acc0[ACCW-1:NARW-1]))); // R12
  AST_STICKY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(sat_sticky) |-> ($past(opcode) == OP_CLR)); // R13
endmodule

// File: tb/tb_dsp_mac_engine.sv
module tb_dsp_mac_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  opcode = '0;
  logic        acc_sel = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic        is_signed = 1'b1, frac_mode = 1'b0, sat_en = 1'b1, sat_narrow = 1'b0;
  logic [5:0]  shift_amt = '0;
  logic [39:0] acc0, acc1;
  logic        ovf0, ovf1, sat_sticky;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  longint m_acc [2];
  bit m_ovf [2];
  bit m_sticky;
  localparam longint MASK40 = 64'h0000_00FF_FFFF_FFFF;

  dsp_mac_engine dut (
    .clk(clk), .rst(rst), .opcode(opcode), .acc_sel(acc_sel), .opa(opa), .opb(opb),
    .is_signed(is_signed), .frac_mode(frac_mode), .sat_en(sat_en), .sat_narrow(sat_narrow),
    .shift_amt(shift_amt), .acc0(acc0), .acc1(acc1), .ovf0(ovf0), .ovf1(ovf1),
    .sat_sticky(sat_sticky)
  );

  always #2 clk = ~clk;

  task automatic chk(string tag, string what, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "acc0", longint'(acc0), m_acc[0] & MASK40);
    chk(tag, "acc1", longint'(acc1), m_acc[1] & MASK40);
    chk(tag, "ovf0", longint'(ovf0), longint'(m_ovf[0]));
    chk(tag, "ovf1", longint'(ovf1), longint'(m_ovf[1]));
    chk(tag, "sticky", longint'(sat_sticky), longint'(m_sticky));
  endtask

  function automatic void model(logic [2:0] op, bit sel, logic [15:0] a, logic [15:0] b,
                                logic [5:0] sh);
    longint src = m_acc[sel], oth = m_acc[!sel], p, r, lim;
    int n;
    bit arith = 1'b0;
    if (op == 3'd0 || op == 3'd7) return;
    if (is_signed) p = longint'(shortint'(a)) * longint'(shortint'(b));
    else           p = longint'(a) * longint'(b);
    if (frac_mode) p = p * 2;
    case (op)
      3'd1: begin r = 0; m_sticky = 1'b0; end
      3'd2: r = longint'(int'({b, a}));
      3'd3: begin r = src + p; arith = 1'b1; end
      3'd4: begin r = src - p; arith = 1'b1; end
      3'd5: begin r = src + oth; arith = 1'b1; end
      default: begin
        n = int'($signed(sh));
        if (n > 16) n = 16;
        if (n < -16) n = -16;
        r = (n >= 0) ? (src >>> n) : (src <<< (-n));
        arith = 1'b1;
      end
    endcase
    if (arith) begin
      if (sat_en) begin
        lim = sat_narrow ? (longint'(1) <<< 31) : (longint'(1) <<< 39);
        if (r > lim - 1) begin r = lim - 1; m_sticky = 1'b1; end
        if (r < -lim)    begin r = -lim;    m_sticky = 1'b1; end
      end else r = (r <<< 24) >>> 24;
    end
    m_acc[sel] = r;
    m_ovf[sel] = (r > 64'sd2147483647) || (r < -64'sd2147483648);
  endfunction

  task automatic step(logic [2:0] op, bit sel, logic [15:0] a, logic [15:0] b,
                      logic [5:0] sh, string tag);
    opcode = op; acc_sel = sel; opa = a; opb = b; shift_amt = sh;
    @(posedge clk);
    model(op, sel, a, b, sh);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic mode(bit sg, bit fr, bit se, bit sn);
    is_signed = sg; frac_mode = fr; sat_en = se; sat_narrow = sn;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_acc[0] = 0; m_acc[1] = 0; m_ovf[0] = 0; m_ovf[1] = 0; m_sticky = 0;
    chk("R1", "acc0", longint'(acc0), 0);
    chk("R1", "acc1", longint'(acc1), 0);
    chk("R1", "flags", longint'({ovf0, ovf1, sat_sticky}), 0);
  endtask

  task automatic t_load();
    mode(1, 0, 1, 0);
    step(3'd2, 0, 16'h5678, 16'h1234, 0, "R3");
    chk("R3", "acc0 literal", longint'(acc0), 64'h12345678);
    step(3'd2, 1, 16'h8000, 16'hFFFF, 0, "R3");
    chk("R3", "acc1 literal", longint'(acc1), 64'hFF_FFFF_8000);
    step(3'd1, 0, 16'h1111, 16'h2222, 0, "R2");
    chk("R2", "acc1 kept", longint'(acc1), 64'hFF_FFFF_8000);
  endtask

  task automatic t_mac_signed();
    mode(1, 0, 1, 0);
    step(3'd1, 0, 0, 0, 0, "R2");
    step(3'd3, 0, 16'hFFFD, 16'd5, 0, "R4");
    chk("R4", "-3*5", longint'(acc0), 64'hFF_FFFF_FFF1);
    step(3'd3, 0, 16'h7FFF, 16'h7FFF, 0, "R4");
    step(3'd3, 0, 16'h8000, 16'h8000, 0, "R4");
    step(3'd3, 0, 16'h8000, 16'h7FFF, 0, "R4");
  endtask

  task automatic t_mac_unsigned();
    mode(0, 0, 1, 0);
    step(3'd1, 1, 0, 0, 0, "R2");
    step(3'd3, 1, 16'hFFFF, 16'hFFFF, 0, "R4");
    chk("R4", "unsigned max", longint'(acc1), 64'hFF_FE00_01);
    chk("R12", "ovf1 unsigned", longint'(ovf1), 1);
    step(3'd3, 1, 16'h8000, 16'd2, 0, "R4");
  endtask

  task automatic t_msc();
    mode(1, 0, 1, 0);
    step(3'd1, 0, 0, 0, 0, "R2");
    step(3'd4, 0, 16'd100, 16'd7, 0, "R5");
    chk("R5", "-700", longint'(acc0), 64'hFF_FFFF_FD44);
    step(3'd4, 0, 16'hFFFF, 16'd7, 0, "R5");
  endtask

  task automatic t_frac();
    mode(1, 1, 1, 0);
    step(3'd1, 1, 0, 0, 0, "R2");
    step(3'd3, 1, 16'h4000, 16'h4000, 0, "R6");
    chk("R6", "half*half", longint'(acc1), 64'h2000_0000);
    step(3'd3, 1, 16'h8000, 16'h8000, 0, "R6");
    step(3'd4, 1, 16'h0003, 16'hFFFF, 0, "R6");
    mode(1, 0, 1, 0);
  endtask

  task automatic t_add();
    mode(1, 0, 1, 0);
    step(3'd2, 0, 16'd100, 16'd0, 0, "R7");
    step(3'd2, 1, 16'hFFCE, 16'hFFFF, 0, "R7");
    step(3'd5, 0, 0, 0, 0, "R7");
    chk("R7", "100-50", longint'(acc0), 64'd50);
    step(3'd5, 1, 0, 0, 0, "R7");
    chk("R7", "acc1 zero", longint'(acc1), 0);
  endtask

  task automatic t_shift();
    mode(1, 0, 1, 0);
    step(3'd2, 1, 16'h5678, 16'h1234, 0, "R8");
    step(3'd6, 1, 0, 0, 6'd4, "R8");
    chk("R8", "right 4", longint'(acc1), 64'h0123_4567);
    step(3'd6, 1, 0, 0, 6'h38, "R8");
    step(3'd6, 1, 0, 0, 6'd16, "R8");
    step(3'd6, 1, 0, 0, 6'h30, "R8");
    step(3'd6, 1, 0, 0, 6'd31, "R8");
    step(3'd6, 1, 0, 0, 6'h20, "R8");
    step(3'd2, 1, 16'h0000, 16'h8000, 0, "R8");
    step(3'd6, 1, 0, 0, 6'd8, "R8");
    chk("R8", "arith right", longint'(acc1), 64'hFF_FF80_0000);
  endtask

  task automatic t_sat40();
    mode(1, 0, 1, 0);
    step(3'd1, 0, 0, 0, 0, "R13");
    step(3'd2, 0, 16'hFFFF, 16'h7FFF, 0, "R9");
    step(3'd6, 0, 0, 0, 6'h38, "R12");
    chk("R12", "ovf0 set", longint'(ovf0), 1);
    step(3'd6, 0, 0, 0, 6'h3F, "R9");
    chk("R9", "pos clamp", longint'(acc0), 64'h7F_FFFF_FFFF);
    chk("R13", "sticky", longint'(sat_sticky), 1);
    step(3'd2, 1, 16'h0000, 16'h8000, 0, "R9");
    step(3'd6, 1, 0, 0, 6'h38, "R9");
    step(3'd3, 1, 16'hFFFF, 16'd1, 0, "R9");
    chk("R9", "neg clamp", longint'(acc1), 64'h80_0000_0000);
  endtask

  task automatic t_sat32();
    mode(1, 0, 1, 1);
    step(3'd1, 0, 0, 0, 0, "R13");
    step(3'd2, 0, 16'h0000, 16'h7FFF, 0, "R10");
    step(3'd3, 0, 16'h7FFF, 16'h7FFF, 0, "R10");
    chk("R10", "pos clamp", longint'(acc0), 64'h7FFF_FFFF);
    step(3'd2, 1, 16'h0000, 16'h8000, 0, "R10");
    step(3'd4, 1, 16'h7FFF, 16'h7FFF, 0, "R10");
    chk("R10", "neg clamp", longint'(acc1), 64'hFF_8000_0000);
    step(3'd5, 0, 0, 0, 0, "R10");
    step(3'd6, 0, 0, 0, 6'h3C, "R10");
    mode(1, 0, 1, 0);
  endtask

  task automatic t_wrap();
    mode(1, 0, 0, 0);
    step(3'd1, 0, 0, 0, 0, "R11");
    step(3'd2, 0, 16'hFFFF, 16'h7FFF, 0, "R11");
    step(3'd6, 0, 0, 0, 6'h38, "R11");
    step(3'd6, 0, 0, 0, 6'h3F, "R11");
    chk("R11", "wrapped", longint'(acc0), 64'hFF_FFFF_FE00);
    step(3'd2, 1, 16'hFFFF, 16'h7FFF, 0, "R11");
    step(3'd6, 1, 0, 0, 6'h30, "R11");
    step(3'd5, 1, 0, 0, 0, "R11");
    chk("R11", "no sticky", longint'(sat_sticky), 0);
    mode(1, 0, 1, 0);
  endtask

  task automatic t_nop();
    mode(1, 0, 1, 0);
    step(3'd2, 0, 16'h0001, 16'h0002, 0, "R14");
    step(3'd0, 0, 16'hAAAA, 16'h5555, 6'h30, "R14");
    step(3'd7, 1, 16'h1234, 16'h4321, 6'd3, "R14");
    step(3'd7, 0, 16'hFFFF, 16'hFFFF, 6'd1, "R14");
  endtask

  task automatic t_sticky();
    mode(1, 0, 1, 0);
    step(3'd2, 0, 16'hFFFF, 16'h7FFF, 0, "R13");
    step(3'd6, 0, 0, 0, 6'h30, "R13");
    chk("R13", "set", longint'(sat_sticky), 1);
    step(3'd0, 0, 0, 0, 0, "R13");
    step(3'd2, 0, 16'd5, 16'd0, 0, "R13");
    step(3'd3, 1, 16'd2, 16'd3, 0, "R13");
    chk("R13", "held", longint'(sat_sticky), 1);
    step(3'd1, 1, 0, 0, 0, "R13");
    chk("R13", "cleared", longint'(sat_sticky), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_load();
    t_mac_signed();
    t_mac_unsigned();
    t_msc();
    t_frac();
    t_add();
    t_shift();
    t_sat40();
    t_sat32();
    t_wrap();
    t_nop();
    t_sticky();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule